// File: doc/BRIEF.md
# Password-Fed Watchdog Timer

This block is a watchdog counter for a processor subsystem. Software programs it through two word-wide registers: a control register (enable, configuration lock, run-in-debug, run-in-sleep, strict mode, a 24-bit timeout), and a feed register. The counter is restarted only when one exact 32-bit key is written to the feed register. If software stops feeding it, the counter reaches the timeout and the block raises a one-clock reset request toward the system reset generator.

A lock bit freezes the configuration until the next system reset. In strict mode, misuse is itself treated as a fault and triggers an immediate reset request. Misuse means a wrong key or a write to the locked control register. The block also keeps a small record of why the last reset happened. That record runs on the external reset alone, so software can read it back after a watchdog-initiated reset. The debug-halt and sleep indications come in on plain input pins, and so does a pulse that marks a debugger-requested reset.

Top module: `pwd_watchdog`

## Requirements
- R1: After external reset the control register reads 0x00000000 and `rst_req_o` is low.
- R2: The control register is at byte offset 0x0 and reads back its fields as follows. Bit 0 is enable, bit 1 is lock, bit 2 is run-in-debug and bit 3 is run-in-sleep. Bit 4 is strict mode, bits [6:5] are the reset cause (read-only), bit 7 reads 0 and bits [31:8] are the timeout T.
- R3: A tick is produced every PRESC_DIV clocks of active counting, and each tick advances the counter. The prescaler and the counter both start from zero on the write that enables the block and on every successful feed. `rst_req_o` is high for exactly the one clock after the edge that ends (T+1)*PRESC_DIV active cycles.
- R4: Writing exactly 0x709D1AB3 to byte offset 0x4 restarts the prescaler and the counter. The offset 0x4 register reads 0.
- R5: Without strict mode, writing any other value to offset 0x4 has no effect on the expiry timing.
- R6: Once the lock bit is set, writes to the control register are ignored. Lock stays set until a system or external reset.
- R7: With strict mode set, two kinds of write raise `rst_req_o` for one clock on the edge after the offending write: a wrong key written to offset 0x4, or a write to the locked control register. A correct key raises nothing.
- R8: While `dbg_halt_i` is high and run-in-debug is clear, counting holds. With run-in-debug set, counting continues.
- R9: While `sleep_i` is high and run-in-sleep is clear, counting holds. With run-in-sleep set, counting continues.
- R10: The reset cause is 0 after an external reset. It is 2 on the edge after any `rst_req_o`, and 1 after a `dbg_rst_i` pulse (watchdog request has priority). It is unchanged by `rst_sys_n_i`.
- R11: With enable clear, the counter stays at zero and no timeout request occurs. With T=0 and enable set, the request follows after one prescaler period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ext_n_i | input | 1 | External reset, synchronous, active low; resets everything |
| rst_sys_n_i | input | 1 | System reset from the reset generator, synchronous, active low; spares the cause record |
| bus_we_i | input | 1 | Register write strobe, one clock per write |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| dbg_halt_i | input | 1 | CPU is halted in debug mode |
| sleep_i | input | 1 | CPU is in sleep |
| dbg_rst_i | input | 1 | One-clock pulse marking a debugger-requested reset |
| rst_req_o | output | 1 | Reset request toward the system reset generator |

## Verification
The bound checker watches these rules on every cycle: lock stickiness and the frozen configuration, the counter clearing after a good feed, the counter holding under debug halt or sleep when counting there is not allowed, the cause record taking the watchdog code after each request, and a block that is disabled and not in strict mode never requesting a reset. Only the directed scenarios can show the exact expiry cycle for a given timeout and prescaler. The same holds for a wrong key leaving that timing untouched, the strict-mode punishments, the cause record surviving a system reset, and the restart of counting when a halt is released.

// File: rtl/pwd_watchdog_pkg.sv
// Shared constants and types for the password-fed watchdog.
// Assumes a 32-bit register interface with byte offsets.
package pwd_watchdog_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned TIMEOUT_W  = 24;
    localparam int unsigned TIMEOUT_LSB = 8;

    // Control register bit positions
    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_LOCK   = 1;
    localparam int unsigned BIT_DBG    = 2;
    localparam int unsigned BIT_SLP    = 3;
    localparam int unsigned BIT_STRICT = 4;
    localparam int unsigned BIT_CAUSE  = 5;

    // Byte offsets of the two registers
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_FEED = 8'h04;

    // The only value that feeds the counter
    localparam logic [DATA_W-1:0] FEED_KEY = 32'h709D_1AB3;

    typedef enum logic [1:0] {
        CAUSE_EXT = 2'd0,
        CAUSE_DBG = 2'd1,
        CAUSE_WDT = 2'd2
    } cause_t;

    typedef struct packed {
        logic [TIMEOUT_W-1:0] timeout;
        logic                 strict;
        logic                 run_slp;
        logic                 run_dbg;
        logic                 lock;
        logic                 en;
    } wd_cfg_t;

endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: control register with lock, feed-key
// decode and strict-mode misuse detection.
// Assumes one-clock write strobes; reads are combinational on the offset.
module wdt_regs
    import pwd_watchdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  cause_t            cause_i,
    output wd_cfg_t           cfg_o,
    output logic              cfg_wr_o,
    output logic              feed_ok_o,
    output logic              misuse_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = OFS_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_FEED = OFS_FEED[ADDR_W-1:0];

    wd_cfg_t cfg_q;
    logic    hit_ctrl;
    logic    hit_feed;
    logic    key_ok;

    // Decode the access target and check the key
    always_comb begin
        hit_ctrl = we_i && (addr_i == A_CTRL);
        hit_feed = we_i && (addr_i == A_FEED);
        key_ok   = (wdata_i == FEED_KEY);
    end

    // Feed request and strict-mode misuse flags
    always_comb begin
        feed_ok_o = hit_feed && key_ok;
        misuse_o  = cfg_q.strict &&
                    ((hit_feed && !key_ok) || (hit_ctrl && cfg_q.lock));
        cfg_wr_o  = hit_ctrl && !cfg_q.lock;
    end

    // Control register: loads only while unlocked
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cfg_q <= '0;
        end else if (cfg_wr_o) begin
            cfg_q.en      <= wdata_i[BIT_EN];
            cfg_q.lock    <= wdata_i[BIT_LOCK];
            cfg_q.run_dbg <= wdata_i[BIT_DBG];
            cfg_q.run_slp <= wdata_i[BIT_SLP];
            cfg_q.strict  <= wdata_i[BIT_STRICT];
            cfg_q.timeout <= wdata_i[TIMEOUT_LSB +: TIMEOUT_W];
        end
    end

    // Read-back mux
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) begin
            rdata_o[BIT_EN]                       = cfg_q.en;
            rdata_o[BIT_LOCK]                     = cfg_q.lock;
            rdata_o[BIT_DBG]                      = cfg_q.run_dbg;
            rdata_o[BIT_SLP]                      = cfg_q.run_slp;
            rdata_o[BIT_STRICT]                   = cfg_q.strict;
            rdata_o[BIT_CAUSE +: 2]               = cause_i;
            rdata_o[TIMEOUT_LSB +: TIMEOUT_W]     = cfg_q.timeout;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/wdt_tick.sv
// Prescaler: emits one tick every DIV active cycles. Restarts from zero
// on a clear and holds its phase while not active.
module wdt_tick #(
    parameter int unsigned DIV = 16
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clr_i,
    input  logic active_i,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_direct
            // No division: every active cycle is a tick
            assign tick_o = active_i && !clr_i;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            assign tick_o = active_i && !clr_i && (phase_q == LAST);

            // Phase counter with wrap at DIV-1
            always_ff @(posedge clk_i) begin
                if (!rst_n_i || clr_i) begin
                    phase_q <= '0;
                end else if (active_i) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_count.sv
// Timeout counter: advances on ticks, flags expiry when a tick arrives
// with the count at or above the timeout, then starts over.
module wdt_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = tick_i && (cnt_q >= limit_i);
    assign count_o  = cnt_q;

    // Count ticks; clear on restart or expiry
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_cause.sv
// Reset-cause record. Runs on the external reset only so that the value
// survives a reset that the watchdog itself requested.
module wdt_cause
    import pwd_watchdog_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ext_n_i,
    input  logic   wdt_req_i,
    input  logic   dbg_req_i,
    output cause_t cause_o
);

    cause_t cause_q;

    // Capture the latest reset source, watchdog first
    always_ff @(posedge clk_i) begin
        if (!rst_ext_n_i) begin
            cause_q <= CAUSE_EXT;
        end else if (wdt_req_i) begin
            cause_q <= CAUSE_WDT;
        end else if (dbg_req_i) begin
            cause_q <= CAUSE_DBG;
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/pwd_watchdog.sv
// Password-fed watchdog top. Combines the register file, prescaler,
// timeout counter and cause record; registers the reset request.
// Assumes rst_sys_n_i is driven by the system reset generator after a request.
module pwd_watchdog
    import pwd_watchdog_pkg::*;
#(
    parameter int unsigned PRESC_DIV = 16,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ext_n_i,
    input  logic              rst_sys_n_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              dbg_halt_i,
    input  logic              sleep_i,
    input  logic              dbg_rst_i,
    output logic              rst_req_o
);

    logic                 core_rst_n;
    wd_cfg_t              cfg;
    logic                 cfg_wr;
    logic                 feed_ok;
    logic                 misuse;
    cause_t               cause;
    logic                 active;
    logic                 restart;
    logic                 tick;
    logic [TIMEOUT_W-1:0] count;
    logic                 expire;
    logic                 req_q;

    // Main logic resets on either reset source
    assign core_rst_n = rst_ext_n_i && rst_sys_n_i;

    // Counting is allowed unless a halt state forbids it
    always_comb begin
        active  = cfg.en && !(dbg_halt_i && !cfg.run_dbg)
                         && !(sleep_i && !cfg.run_slp);
        restart = feed_ok || !cfg.en;
    end

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i    (clk_i),
        .rst_n_i  (core_rst_n),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .cause_i  (cause),
        .cfg_o    (cfg),
        .cfg_wr_o (cfg_wr),
        .feed_ok_o(feed_ok),
        .misuse_o (misuse),
        .rdata_o  (bus_rdata_o)
    );

    wdt_tick #(.DIV(PRESC_DIV)) u_tick (
        .clk_i   (clk_i),
        .rst_n_i (core_rst_n),
        .clr_i   (restart),
        .active_i(active),
        .tick_o  (tick)
    );

    wdt_count #(.CNT_W(TIMEOUT_W)) u_count (
        .clk_i   (clk_i),
        .rst_n_i (core_rst_n),
        .clr_i   (restart),
        .tick_i  (tick),
        .limit_i (cfg.timeout),
        .count_o (count),
        .expire_o(expire)
    );

    wdt_cause u_cause (
        .clk_i      (clk_i),
        .rst_ext_n_i(rst_ext_n_i),
        .wdt_req_i  (req_q),
        .dbg_req_i  (dbg_rst_i),
        .cause_o    (cause)
    );

    // Registered one-clock reset request
    always_ff @(posedge clk_i) begin
        if (!core_rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= expire || misuse;
        end
    end

    assign rst_req_o = req_q;

endmodule

// File: rtl/wdt_checker.sv
// Cycle-level rules of the watchdog, bound into the top module.
module wdt_checker
    import pwd_watchdog_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ext_n_i,
    input logic                 core_rst_n,
    input logic                 bus_we_i,
    input logic                 dbg_halt_i,
    input logic                 sleep_i,
    input wd_cfg_t              cfg,
    input logic                 feed_ok,
    input logic [TIMEOUT_W-1:0] count,
    input cause_t               cause,
    input logic                 rst_req_o
);

    // R6: lock stays set until a reset
    a_r6_lock_sticks: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        cfg.lock |=> cfg.lock);

    // R6: locked configuration does not change
    a_r6_cfg_frozen: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        cfg.lock |=> $stable(cfg));

    // R4: a good feed leaves the counter at zero
    a_r4_feed_clears: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        feed_ok |=> (count == '0));

    // R8: debug halt holds the counter when not allowed to run
    a_r8_debug_hold: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        (cfg.en && dbg_halt_i && !cfg.run_dbg && !bus_we_i) |=> $stable(count));

    // R9: sleep holds the counter when not allowed to run
    a_r9_sleep_hold: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        (cfg.en && sleep_i && !cfg.run_slp && !bus_we_i) |=> $stable(count));

    // R10: every request is recorded as a watchdog cause
    a_r10_cause_wdt: assert property (@(posedge clk_i) disable iff (!rst_ext_n_i)
        rst_req_o |=> (cause == CAUSE_WDT));

    // R11: disabled and non-strict means no request
    a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!core_rst_n)
        (!cfg.en && !cfg.strict) |=> !rst_req_o);

endmodule

bind pwd_watchdog wdt_checker u_wdt_checker (
    .clk_i      (clk_i),
    .rst_ext_n_i(rst_ext_n_i),
    .core_rst_n (core_rst_n),
    .bus_we_i   (bus_we_i),
    .dbg_halt_i (dbg_halt_i),
    .sleep_i    (sleep_i),
    .cfg        (cfg),
    .feed_ok    (feed_ok),
    .count      (count),
    .cause      (cause),
    .rst_req_o  (rst_req_o)
);

// File: tb/pwd_watchdog_tb_top.sv
// Directed bench for the password-fed watchdog.
module pwd_watchdog_tb_top;

    localparam int unsigned DIV    = 4;
    localparam int unsigned ADDR_W = 4;
    localparam logic [31:0] KEY    = 32'h709D_1AB3;

    logic              clk = 1'b0;
    logic              rst_ext_n = 1'b0;
    logic              rst_sys_n = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              dbg_halt = 1'b0;
    logic              sleep = 1'b0;
    logic              dbg_rst = 1'b0;
    logic              req;

    int errs = 0;
    int checks = 0;
    logic [1:0] exp_cause = 2'd0;

    always #10 clk = ~clk;

    pwd_watchdog #(.PRESC_DIV(DIV), .ADDR_W(ADDR_W)) dut_i (
        .clk_i      (clk),
        .rst_ext_n_i(rst_ext_n),
        .rst_sys_n_i(rst_sys_n),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .dbg_halt_i (dbg_halt),
        .sleep_i    (sleep),
        .dbg_rst_i  (dbg_rst),
        .rst_req_o  (req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; called at a negedge, returns at the next negedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
        addr = '0;
    endtask

    task automatic req_after(input int n, input string tag);
        repeat (n - 1) @(negedge clk);
        chk({tag, " before expiry"}, {31'd0, req}, 32'd0);
        @(negedge clk);
        chk({tag, " at expiry"}, {31'd0, req}, 32'd1);
        exp_cause = 2'd2;
    endtask

    task automatic sys_rst();
        rst_sys_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_sys_n = 1'b1;
    endtask

    task automatic quiet_for(input int n, input string tag);
        logic seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            seen |= req;
        end
        chk(tag, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v);
        chk("R1 ctrl after reset", v, 32'h0);
        chk("R1 request after reset", {31'd0, req}, 32'd0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(4'h0, 32'hABCD_EF1C);
        rd(4'h0, v);
        chk("R2 field readback", v, 32'hABCD_EF1C);
        rd(4'h4, v);
        chk("R4 feed reg reads zero", v, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(4'h0, 32'h0000_0301);
        req_after(4 * DIV, "R3 T=3");
        @(negedge clk);
        chk("R3 one-clock pulse", {31'd0, req}, 32'd0);
        sys_rst();
        rd(4'h0, v);
        chk("R10 cause after timeout", v, 32'h0000_0040);
    endtask

    task automatic t_feed();
        wr(4'h0, 32'h0000_0301);
        repeat (3) @(negedge clk);
        wr(4'h4, KEY);
        req_after(4 * DIV, "R4 good key restarts");
        sys_rst();
    endtask

    task automatic t_badkey();
        wr(4'h0, 32'h0000_0301);
        repeat (3) @(negedge clk);
        wr(4'h4, KEY ^ 32'h1);
        req_after(4 * DIV - 4, "R5 wrong key ignored");
        sys_rst();
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(4'h0, 32'h0000_C803);
        wr(4'h0, 32'h0);
        rd(4'h0, v);
        chk("R6 locked write ignored", v, 32'h0000_C803 | {25'd0, exp_cause, 5'd0});
        chk("R6 no request non-strict", {31'd0, req}, 32'd0);
        sys_rst();
        rd(4'h0, v);
        chk("R6 lock cleared by reset", v, {25'd0, exp_cause, 5'd0});
    endtask

    task automatic t_strict();
        logic [31:0] v;
        wr(4'h0, 32'h0000_C811);
        wr(4'h4, KEY);
        chk("R7 good key no request", {31'd0, req}, 32'd0);
        wr(4'h4, 32'h1234_5678);
        chk("R7 wrong key request", {31'd0, req}, 32'd1);
        @(negedge clk);
        chk("R7 request lasts one clock", {31'd0, req}, 32'd0);
        sys_rst();
        wr(4'h0, 32'h0000_0012);
        chk("R7 lock write alone quiet", {31'd0, req}, 32'd0);
        wr(4'h0, 32'h0);
        chk("R7 locked write request", {31'd0, req}, 32'd1);
        sys_rst();
        rd(4'h0, v);
        chk("R10 cause after strict", v, 32'h0000_0040);
    endtask

    task automatic t_halt(input logic use_dbg);
        logic [31:0] base = use_dbg ? 32'h0000_0105 : 32'h0000_0109;
        logic [31:0] hold = use_dbg ? 32'h0000_0101 : 32'h0000_0101;
        string tag = use_dbg ? "R8" : "R9";
        if (use_dbg) dbg_halt = 1'b1; else sleep = 1'b1;
        wr(4'h0, hold);
        quiet_for(30, {tag, " held while halted"});
        dbg_halt = 1'b0; sleep = 1'b0;
        req_after(2 * DIV, {tag, " resumes after release"});
        sys_rst();
        if (use_dbg) dbg_halt = 1'b1; else sleep = 1'b1;
        wr(4'h0, base);
        req_after(2 * DIV, {tag, " runs when allowed"});
        dbg_halt = 1'b0; sleep = 1'b0;
        sys_rst();
    endtask

    task automatic t_cause();
        logic [31:0] v;
        dbg_rst = 1'b1;
        @(negedge clk);
        dbg_rst = 1'b0;
        sys_rst();
        rd(4'h0, v);
        chk("R10 debugger cause survives", v, 32'h0000_0020);
        rst_ext_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_ext_n = 1'b1;
        rd(4'h0, v);
        chk("R10 external cause", v, 32'h0);
        exp_cause = 2'd0;
    endtask

    task automatic t_disabled();
        wr(4'h0, 32'h0000_0000);
        quiet_for(50, "R11 disabled stays quiet");
        wr(4'h0, 32'h0000_0001);
        req_after(DIV, "R11 T=0 one period");
        sys_rst();
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_ext_n = 1'b1;
        rst_sys_n = 1'b1;
        t_reset();
        t_fields();
        t_timeout();
        t_feed();
        t_badkey();
        t_lock();
        t_strict();
        t_halt(1'b1);
        t_halt(1'b0);
        t_cause();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule